// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a virtual address into a physical address using a small bank of segment descriptor registers. Every descriptor carries a valid bit, a virtual base, a length, a physical start and two signed ring brackets: one for reads and one for writes. A request supplies the virtual address, whether the access is a read or a write, and the ring the requester runs in. One cycle later the block returns either the relocated address or a fault with a cause code.

Privileged logic loads descriptors through a configuration port. A write lands only while the privilege input is high. Each descriptor covers its addresses in the same way, so a descriptor whose base is zero acts as a plain base/limit pair. The mapping never depends on the kind of access. The brackets only decide whether the access may go ahead, so one segment can be readable from a ring that is not allowed to write it.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor is invalid and `rsp_valid` is 0. A request issued before any descriptor is written faults with cause 2'b01.
- R2: An address n with vbase ≤ n < vbase+len in a valid descriptor, and a permitted access, returns `rsp_paddr` = (pbase + (n − vbase)) modulo 2^PA_W, `rsp_fault` = 0 and `rsp_cause` = 2'b00. For a given address, a read and a write that are both permitted return the same physical address.
- R3: An address covered by no valid descriptor returns `rsp_fault` = 1, `rsp_cause` = 2'b01 and `rsp_paddr` = 0. A descriptor with length 0 covers no address. A fault of either cause drives `rsp_paddr` to 0.
- R4: A read is permitted only when the read bracket is 0 or more and `req_ring` is not above it. Otherwise it faults with cause 2'b10.
- R5: A write is permitted only when the write bracket is 0 or more and `req_ring` is not above it. Otherwise it faults with cause 2'b10.
- R6: A negative bracket (sign bit set, two's complement) denies that kind of access from every ring, ring 0 included.
- R7: When several valid descriptors cover an address, the one with the lowest index decides both the translation and the permission.
- R8: A descriptor whose valid bit is 0 takes no part in matching. The address falls through to the other descriptors.
- R9: A configuration write with `cfg_priv` low leaves every descriptor unchanged. A privileged write affects requests from the next cycle on.
- R10: A descriptor with vbase 0 behaves as a base/limit pair. An address below the length relocates to address + pbase, and an address at or above the length faults with cause 2'b01.
- R11: `rsp_valid` is `req_valid` delayed by exactly one cycle. In a cycle after an idle request cycle, `rsp_paddr`, `rsp_fault` and `rsp_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Privileged-mode qualifier for descriptor writes |
| cfg_idx | input | IDX_W | Descriptor slot to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_vbase | input | VA_W | Virtual base to store |
| cfg_len | input | VA_W | Segment length to store |
| cfg_pbase | input | PA_W | Physical start to store |
| cfg_rd_br | input | RING_W+1 | Signed read bracket to store |
| cfg_wr_br | input | RING_W+1 | Signed write bracket to store |
| req_valid | input | 1 | Request present |
| req_addr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ring | input | RING_W | Current ring of the requester |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | PA_W | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 00 none, 01 out of range, 10 bracket violation |

## Verification
Directed requests probe the first and last covered addresses and the address one past the end. They separate a correct bound from an off-by-one error at each edge. Ring sweeps on either side of each bracket, together with negative brackets, show whether the read and write checks use the right bracket and the right comparison. Overlapping and invalidated descriptors, an unprivileged write and a base/limit slot with physical wrap-around show priority, valid gating, write protection and modulo arithmetic. A long random run mixes requests with privileged and unprivileged descriptor writes in the same cycle, which checks that a request always sees the table as it stood before that cycle's write.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_RANGE   = 2'b01,
        CAUSE_BRACKET = 2'b10
    } seg_cause_e;
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank #(
    parameter int VA_W    = 16,
    parameter int PA_W    = 20,
    parameter int RING_W  = 3,
    parameter int NUM_SEG = 4,
    localparam int BR_W   = RING_W + 1,
    localparam int DESC_W = 1 + 2 * VA_W + PA_W + 2 * BR_W,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic                             cfg_priv,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [DESC_W-1:0]                cfg_desc,
    output logic [NUM_SEG-1:0][DESC_W-1:0]   desc_flat
);
    typedef struct packed {
        logic [NUM_SEG-1:0][DESC_W-1:0] tbl;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we && cfg_priv && (int'(cfg_idx) < NUM_SEG)) begin
            state_d.tbl[cfg_idx] = cfg_desc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign desc_flat = state_q.tbl;

    // R9: unprivileged configuration traffic must not disturb the table
    assert_nopriv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> $stable(state_q.tbl));
endmodule

// File: rtl/seg_range_match.sv
module seg_range_match #(
    parameter int VA_W    = 16,
    parameter int PA_W    = 20,
    parameter int RING_W  = 3,
    parameter int NUM_SEG = 4,
    localparam int BR_W   = RING_W + 1,
    localparam int DESC_W = 1 + 2 * VA_W + PA_W + 2 * BR_W
) (
    input  logic [NUM_SEG-1:0][DESC_W-1:0] desc_flat,
    input  logic [VA_W-1:0]                addr,
    output logic                           hit,
    output logic [DESC_W-1:0]              sel_desc
);
    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vbase;
        logic [VA_W-1:0] len;
        logic [PA_W-1:0] pbase;
        logic [BR_W-1:0] rd_br;
        logic [BR_W-1:0] wr_br;
    } desc_t;

    logic [NUM_SEG-1:0] hit_vec;

    for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_cmp
        desc_t           d;
        logic [VA_W-1:0] off;
        assign d          = desc_t'(desc_flat[gi]);
        assign off        = addr - d.vbase;
        assign hit_vec[gi] = d.valid && (addr >= d.vbase) && (off < d.len);
    end

    always_comb begin
        sel_desc = '0;
        for (int i = NUM_SEG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_desc = desc_flat[i];
            end
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int PA_W    = 20,
    parameter int RING_W  = 3,
    parameter int NUM_SEG = 4,
    localparam int BR_W   = RING_W + 1,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [VA_W-1:0]   cfg_vbase,
    input  logic [VA_W-1:0]   cfg_len,
    input  logic [PA_W-1:0]   cfg_pbase,
    input  logic [BR_W-1:0]   cfg_rd_br,
    input  logic [BR_W-1:0]   cfg_wr_br,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic [RING_W-1:0] req_ring,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    localparam int DESC_W = 1 + 2 * VA_W + PA_W + 2 * BR_W;
    localparam int SUM_W  = (PA_W > VA_W) ? PA_W : VA_W;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vbase;
        logic [VA_W-1:0] len;
        logic [PA_W-1:0] pbase;
        logic [BR_W-1:0] rd_br;
        logic [BR_W-1:0] wr_br;
    } desc_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            fault;
        seg_cause_e      cause;
    } rsp_t;

    logic [NUM_SEG-1:0][DESC_W-1:0] desc_flat;
    logic [DESC_W-1:0]              cfg_desc, sel_flat;
    logic                           hit;
    desc_t                          sel;
    rsp_t                           rsp_d, rsp_q;

    assign cfg_desc = {cfg_valid, cfg_vbase, cfg_len, cfg_pbase, cfg_rd_br, cfg_wr_br};

    seg_desc_bank #(
        .VA_W(VA_W), .PA_W(PA_W), .RING_W(RING_W), .NUM_SEG(NUM_SEG)
    ) i_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_idx(cfg_idx), .cfg_desc(cfg_desc), .desc_flat(desc_flat)
    );

    seg_range_match #(
        .VA_W(VA_W), .PA_W(PA_W), .RING_W(RING_W), .NUM_SEG(NUM_SEG)
    ) i_match (
        .desc_flat(desc_flat), .addr(req_addr), .hit(hit), .sel_desc(sel_flat)
    );

    assign sel = desc_t'(sel_flat);

    always_comb begin
        logic [BR_W-1:0]  br;
        logic [VA_W-1:0]  off;
        logic [SUM_W-1:0] sum;
        rsp_d = '0;
        br    = req_write ? sel.wr_br : sel.rd_br;
        off   = req_addr - sel.vbase;
        sum   = SUM_W'(sel.pbase) + SUM_W'(off);
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!hit) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = CAUSE_RANGE;
            end else if (br[BR_W-1] || ({1'b0, req_ring} > br)) begin
                rsp_d.fault = 1'b1;
                rsp_d.cause = CAUSE_BRACKET;
            end else begin
                rsp_d.paddr = sum[PA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;

    // R11: response strobe trails the request strobe by one cycle
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));
    // R3: a miss in the match stage surfaces as a range fault
    assert_miss_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_fault && rsp_cause == CAUSE_RANGE && rsp_paddr == '0));
    // R6: a negative read bracket refuses every ring
    assert_neg_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !req_write && sel.rd_br[BR_W-1]) |=> (rsp_cause == CAUSE_BRACKET));
    // R5: a write from a ring above the write bracket is refused
    assert_write_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_write && ({1'b0, req_ring} > sel.wr_br))
        |=> (rsp_fault && rsp_cause == CAUSE_BRACKET));
endmodule

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;
    localparam int VA_W = 16, PA_W = 20, RING_W = 3, NUM_SEG = 4;
    localparam int BR_W = RING_W + 1, IDX_W = 2;
    localparam int PA_MASK = (1 << PA_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_priv = 0, cfg_valid = 0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [VA_W-1:0] cfg_vbase = '0, cfg_len = '0;
    logic [PA_W-1:0] cfg_pbase = '0;
    logic [BR_W-1:0] cfg_rd_br = '0, cfg_wr_br = '0;
    logic req_valid = 0, req_write = 0;
    logic [VA_W-1:0] req_addr = '0;
    logic [RING_W-1:0] req_ring = '0;
    logic rsp_valid, rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0] rsp_cause;

    int n_tests = 0, n_fail = 0;
    int sh_v[NUM_SEG], sh_b[NUM_SEG], sh_len[NUM_SEG], sh_m[NUM_SEG], sh_rb[NUM_SEG], sh_wb[NUM_SEG];

    always #2 clk = ~clk;

    seg_xlate_unit #(.VA_W(VA_W), .PA_W(PA_W), .RING_W(RING_W), .NUM_SEG(NUM_SEG)) i_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_vbase(cfg_vbase), .cfg_len(cfg_len), .cfg_pbase(cfg_pbase),
        .cfg_rd_br(cfg_rd_br), .cfg_wr_br(cfg_wr_br), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ring(req_ring), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause));

    function automatic void model(input int n, input bit wr, input int ring, output int pa, output int cause);
        pa = 0; cause = 1;
        for (int i = NUM_SEG - 1; i >= 0; i--) begin
            if (sh_v[i] != 0 && n >= sh_b[i] && (n - sh_b[i]) < sh_len[i]) begin
                int br;
                br = wr ? sh_wb[i] : sh_rb[i];
                if (br < 0 || ring > br) begin pa = 0; cause = 2; end
                else begin pa = (sh_m[i] + n - sh_b[i]) & PA_MASK; cause = 0; end
            end
        end
    endfunction

    task automatic check_rsp(input string rq, input int ev, input int epa, input int ec);
        n_tests++;
        if (rsp_valid !== ev[0] || rsp_paddr !== epa[PA_W-1:0] || rsp_cause !== ec[1:0]
            || rsp_fault !== (ec != 0)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0d paddr=%h cause=%0d fault=%0d, expected valid=%0d paddr=%h cause=%0d fault=%0d",
                     rq, rsp_valid, rsp_paddr, rsp_cause, rsp_fault, ev, epa[PA_W-1:0], ec, (ec != 0));
        end
    endtask

    task automatic put_cfg(input int idx, input int v, input int b, input int len, input int m,
                           input int rb, input int wb, input bit priv);
        cfg_we = 1; cfg_priv = priv; cfg_idx = idx[IDX_W-1:0]; cfg_valid = v[0];
        cfg_vbase = b[VA_W-1:0]; cfg_len = len[VA_W-1:0]; cfg_pbase = m[PA_W-1:0];
        cfg_rd_br = rb[BR_W-1:0]; cfg_wr_br = wb[BR_W-1:0];
        if (priv) begin
            sh_v[idx] = v; sh_b[idx] = b & 16'hFFFF; sh_len[idx] = len & 16'hFFFF;
            sh_m[idx] = m & PA_MASK; sh_rb[idx] = rb; sh_wb[idx] = wb;
        end
    endtask

    task automatic do_cfg(input int idx, input int v, input int b, input int len, input int m,
                          input int rb, input int wb, input bit priv);
        put_cfg(idx, v, b, len, m, rb, wb, priv);
        @(negedge clk);
        cfg_we = 0; cfg_priv = 0;
    endtask

    task automatic do_req(input string rq, input int n, input bit wr, input int ring);
        int pa, c;
        model(n, wr, ring, pa, c);
        req_valid = 1; req_addr = n[VA_W-1:0]; req_write = wr; req_ring = ring[RING_W-1:0];
        @(negedge clk);
        req_valid = 0;
        check_rsp(rq, 1, pa, c);
    endtask

    task automatic do_req_exp(input string rq, input int n, input bit wr, input int ring,
                              input int epa, input int ec);
        req_valid = 1; req_addr = n[VA_W-1:0]; req_write = wr; req_ring = ring[RING_W-1:0];
        @(negedge clk);
        req_valid = 0;
        check_rsp(rq, 1, epa, ec);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NUM_SEG; i++) begin
            sh_v[i] = 0; sh_b[i] = 0; sh_len[i] = 0; sh_m[i] = 0; sh_rb[i] = 0; sh_wb[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_rsp("R1 reset idle", 0, 0, 0);
        do_req_exp("R1 empty table", 16'h0000, 0, 0, 0, 1);

        // R2 / R3 / R4 / R5 on slot 0
        do_cfg(0, 1, 16'h1000, 16'h0100, 20'h40000, 3, 1, 1);
        do_req_exp("R2 inside", 16'h1010, 0, 2, 20'h40010, 0);
        do_req_exp("R2 first", 16'h1000, 0, 0, 20'h40000, 0);
        do_req_exp("R2 last", 16'h10FF, 0, 0, 20'h400FF, 0);
        do_req_exp("R3 one past end", 16'h1100, 0, 0, 0, 1);
        do_req_exp("R3 below base", 16'h0FFF, 0, 0, 0, 1);
        do_req_exp("R4 ring at read bracket", 16'h1020, 0, 3, 20'h40020, 0);
        do_req_exp("R4 ring above read bracket", 16'h1020, 0, 4, 0, 2);
        do_req_exp("R5 ring at write bracket", 16'h1020, 1, 1, 20'h40020, 0);
        do_req_exp("R5 ring above write bracket", 16'h1020, 1, 2, 0, 2);
        // R11: idle cycle yields no response
        @(negedge clk);
        check_rsp("R11 idle gap", 0, 0, 0);

        // R6: negative brackets
        do_cfg(1, 1, 16'h2000, 16'h0010, 20'h00100, -1, -2, 1);
        do_req_exp("R6 read ring0 negative", 16'h2004, 0, 0, 0, 2);
        do_req_exp("R6 write ring0 negative", 16'h2004, 1, 0, 0, 2);

        // R7: overlapping slots, lowest index wins
        do_cfg(2, 1, 16'h3000, 16'h0020, 20'h00500, 7, 7, 1);
        do_cfg(3, 1, 16'h3000, 16'h0040, 20'h00900, 0, -1, 1);
        do_req_exp("R7 overlap lower index", 16'h3010, 1, 5, 20'h00510, 0);
        do_req_exp("R7 only upper slot", 16'h3030, 0, 0, 20'h00930, 0);

        // R8: invalidated slot falls through
        do_cfg(2, 0, 16'h3000, 16'h0020, 20'h00500, 7, 7, 1);
        do_req_exp("R8 invalid slot skipped", 16'h3010, 0, 0, 20'h00910, 0);
        do_req_exp("R8 fallthrough brackets", 16'h3010, 0, 1, 0, 2);

        // R9: unprivileged write ignored
        do_cfg(3, 1, 16'h5000, 16'h0010, 20'h00000, 7, 7, 0);
        do_req_exp("R9 table unchanged", 16'h3030, 0, 0, 20'h00930, 0);
        do_req_exp("R9 no new range", 16'h5004, 0, 0, 0, 1);

        // R10: base/limit with physical wrap; R3 zero length
        do_cfg(0, 1, 16'h0000, 16'h0080, 20'hFFFF0, 7, 7, 1);
        do_req_exp("R10 below limit wraps", 16'h007F, 0, 0, 20'h0006F, 0);
        do_req_exp("R10 at limit", 16'h0080, 1, 0, 0, 1);
        do_cfg(1, 1, 16'h2000, 16'h0000, 20'h00100, 7, 7, 1);
        do_req_exp("R3 zero length", 16'h2000, 0, 0, 0, 1);

        // Random phase: R2 R3 R4 R5 R7 R9 R11
        for (int it = 0; it < 3000; it++) begin
            bit do_r;
            int pa, c;
            do_r = ($urandom_range(0, 9) < 8);
            model(0, 0, 0, pa, c);
            if (do_r) begin
                req_addr  = 16'(($urandom_range(0, 3) << 12) + $urandom_range(0, 16'h03FF));
                req_write = 1'($urandom_range(0, 1));
                req_ring  = 3'($urandom_range(0, 7));
                model(int'(req_addr), req_write, int'(req_ring), pa, c);
            end
            req_valid = do_r;
            if ($urandom_range(0, 9) == 0) begin
                put_cfg($urandom_range(0, 3), ($urandom_range(0, 3) != 0),
                        ($urandom_range(0, 3) << 12) + $urandom_range(0, 16'h00FF),
                        $urandom_range(0, 16'h0200), $urandom_range(0, PA_MASK),
                        $urandom_range(0, 9) - 2, $urandom_range(0, 9) - 2,
                        ($urandom_range(0, 1) == 1));
            end
            @(negedge clk);
            cfg_we = 0; cfg_priv = 0; req_valid = 0;
            if (do_r) check_rsp("R2-R9 random request", 1, pa, c);
            else      check_rsp("R11 random idle", 0, 0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule